// File: doc/BRIEF.md
# Voltage-ID Slew Ramp Controller

This block moves a regulator's voltage-ID code from its present value to a newly requested target one code at a time. It waits a fixed interval between codes, so the converter output changes at a bounded rate. While it is moving it raises a power-good mask, and it asks the converter to run in forced PWM unless decay mode is selected. When the move ends it gives a one-cycle done pulse. A separate clock divider sets the step interval from a clock-cycles-per-microsecond parameter. A static select picks a 3 µs interval for fine codes or a 6 µs interval for coarse codes.

Two cases get their own sequence. A target of code 0 walks the code down to a floor code, which stands for the lowest regulated level. The block then turns switching off and leaves the output to decay. Starting again from below the floor is a three-phase sequence. The block requests soft-start and holds for a fixed wait. It then loads the floor code and climbs to the target at the normal rate. Forced PWM is never requested during any part of this restart.

Top module: `vid_slew_ctrl`

## Requirements
- R1: After reset, vid_code is 0, sw_en, force_pwm, pg_mask, soft_start and ramp_done are all 0, and the block is off.
- R2: While switching and settled, a new target different from vid_code starts a ramp. vid_code moves exactly one code toward the target on each step tick. The first tick comes STEP clock edges after the edge that captured the target, and every following tick comes STEP edges after the one before.
- R3: STEP is 3*CLK_PER_US cycles when step_sel is 0, and 6*CLK_PER_US cycles when step_sel is 1.
- R4: During a normal ramp, force_pwm is 1 when decay_mode is 0 and 0 when decay_mode is 1.
- R5: pg_mask is 1 for the whole soft-start and ramp. It drops in the same cycle that ramp_done is raised.
- R6: ramp_done is a single-cycle pulse. It appears in the cycle in which vid_code first equals the destination.
- R7: A target of 0 makes the ramp destination FLOOR_CODE. When the ramp ends, sw_en drops to 0 in the same cycle and vid_code holds FLOOR_CODE.
- R8: While off, a target above FLOOR_CODE with below_floor = 1 sets soft_start, sw_en and pg_mask for SS_US*CLK_PER_US cycles with vid_code unchanged. After that, vid_code loads FLOOR_CODE and a ramp to the target begins with a fresh step timer.
- R9: force_pwm stays 0 during soft-start and during the ramp that follows it, whatever decay_mode is.
- R10: While off, a target is ignored if below_floor is 0 or if the target is at most FLOOR_CODE. All outputs keep their off values.
- R11: A target written during a ramp becomes the new destination. The direction is recomputed from the current vid_code, and the step timer keeps its phase.
- R12: Apart from the floor load at the end of soft-start, vid_code changes by at most one code per clock, and only on a step tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_vid | input | VID_W | Requested target code |
| decay_mode | input | 1 | 1 lets the output decay; no forced PWM during ramps |
| step_sel | input | 1 | 0: fine step interval, 1: coarse step interval |
| below_floor | input | 1 | Output is below the floor level |
| vid_code | output | VID_W | Present voltage-ID code |
| force_pwm | output | 1 | Forced-PWM request |
| pg_mask | output | 1 | Power-good mask |
| sw_en | output | 1 | Switching enable |
| soft_start | output | 1 | Soft-start request |
| ramp_done | output | 1 | One-cycle end-of-ramp pulse |

## Verification
Time is measured from the rising edge that captures a target, called edge zero. The k-th code change is due k*STEP edges later, and ramp_done and the mask release are due on the last of those edges. A restart adds the soft-start length to that origin. The bench drives all inputs on the falling edge and samples on the next falling edge. It counts each sample as j edges after edge zero and compares against vid = start ± floor(j/STEP). A retarget is written partway through a step interval. This shows the next code change still lands on the original tick grid and not one full interval after the write.

// File: rtl/vid_slew_pkg.sv
package vid_slew_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SOFT = 2'd1,
    ST_RAMP = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;

  // clock cycles between code steps
  function automatic int step_cycles(input int clk_per_us, input bit coarse);
    return coarse ? 6 * clk_per_us : 3 * clk_per_us;
  endfunction

  // clock cycles of the soft-start wait
  function automatic int ss_cycles(input int clk_per_us, input int ss_us);
    return clk_per_us * ss_us;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vid_step_timer.sv
module vid_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  assign hit = run && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/vid_seq_fsm.sv
module vid_seq_fsm
  import vid_slew_pkg::*;
#(
  parameter int           VID_W      = 7,
  parameter int unsigned  FLOOR_CODE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] tgt_vid,
  input  logic             below_floor,
  input  logic             tick,
  output seq_state_e       state,
  output logic [VID_W-1:0] vid,
  output logic [VID_W-1:0] dest,
  output logic             restart,
  output logic             done,
  output logic             tmr_clr
);

  localparam logic [VID_W-1:0] FLOOR = VID_W'(FLOOR_CODE);

  function automatic logic [VID_W-1:0] step_toward(
    input logic [VID_W-1:0] cur, input logic [VID_W-1:0] dst);
    if (cur < dst)      return cur + 1'b1;
    else if (cur > dst) return cur - 1'b1;
    else                return cur;
  endfunction

  seq_state_e       state_q, state_d;
  logic [VID_W-1:0] vid_q, vid_d, stepped;
  logic             rst_q, rst_d, done_d;

  assign dest = (tgt_vid == '0) ? FLOOR : tgt_vid;
  assign stepped = tick ? step_toward(vid_q, dest) : vid_q;

  always_comb begin
    state_d = state_q;
    vid_d   = vid_q;
    rst_d   = rst_q;
    done_d  = 1'b0;
    tmr_clr = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (below_floor && (tgt_vid > FLOOR)) begin
          state_d = ST_SOFT;
          tmr_clr = 1'b1;
        end
      end
      ST_SOFT: begin
        if (tick) begin
          state_d = ST_RAMP;
          vid_d   = FLOOR;
          rst_d   = 1'b1;
          tmr_clr = 1'b1;
        end
      end
      ST_RAMP: begin
        vid_d = stepped;
        if (stepped == dest) begin
          done_d  = 1'b1;
          rst_d   = 1'b0;
          state_d = (tgt_vid == '0) ? ST_OFF : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if ((tgt_vid == '0) && (vid_q == FLOOR)) begin
          state_d = ST_OFF;
        end else if (dest != vid_q) begin
          state_d = ST_RAMP;
          rst_d   = 1'b0;
          tmr_clr = 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      vid_q   <= '0;
      rst_q   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      vid_q   <= vid_d;
      rst_q   <= rst_d;
      done    <= done_d;
    end
  end

  assign state   = state_q;
  assign vid     = vid_q;
  assign restart = rst_q;

endmodule

// File: rtl/vid_slew_ctrl.sv
module vid_slew_ctrl
  import vid_slew_pkg::*;
#(
  parameter int          VID_W      = 7,
  parameter int unsigned FLOOR_CODE = 1,
  parameter int          CLK_PER_US = 125,
  parameter int          SS_US      = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] tgt_vid,
  input  logic             decay_mode,
  input  logic             step_sel,
  input  logic             below_floor,
  output logic [VID_W-1:0] vid_code,
  output logic             force_pwm,
  output logic             pg_mask,
  output logic             sw_en,
  output logic             soft_start,
  output logic             ramp_done
);

  localparam int STEP_FINE   = step_cycles(CLK_PER_US, 1'b0);
  localparam int STEP_COARSE = step_cycles(CLK_PER_US, 1'b1);
  localparam int SS_CYC      = ss_cycles(CLK_PER_US, SS_US);
  localparam int CNT_W       = $clog2(max2(SS_CYC, STEP_COARSE) + 1);

  seq_state_e       state;
  logic [VID_W-1:0] dest;
  logic             restart, tmr_clr, step_tick, ss_done, ramp_active;
  logic [CNT_W-1:0] tmr_limit;

  assign ramp_active = (state == ST_RAMP);
  assign tmr_limit = (state == ST_SOFT) ? CNT_W'(SS_CYC)
                   : (step_sel ? CNT_W'(STEP_COARSE) : CNT_W'(STEP_FINE));
  assign ss_done = step_tick && (state == ST_SOFT);

  vid_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (ramp_active || (state == ST_SOFT)),
    .limit (tmr_limit),
    .hit   (step_tick)
  );

  vid_seq_fsm #(.VID_W(VID_W), .FLOOR_CODE(FLOOR_CODE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_vid     (tgt_vid),
    .below_floor (below_floor),
    .tick        (step_tick),
    .state       (state),
    .vid         (vid_code),
    .dest        (dest),
    .restart     (restart),
    .done        (ramp_done),
    .tmr_clr     (tmr_clr)
  );

  assign pg_mask    = ramp_active || (state == ST_SOFT);
  assign soft_start = (state == ST_SOFT);
  assign sw_en      = (state != ST_OFF);
  assign force_pwm  = ramp_active && !decay_mode && !restart;

endmodule

// File: rtl/vid_slew_chk.sv
module vid_slew_chk #(
  parameter int VID_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             decay_mode,
  input logic [VID_W-1:0] vid_code,
  input logic             force_pwm,
  input logic             pg_mask,
  input logic             sw_en,
  input logic             soft_start,
  input logic             ramp_done,
  input logic             step_tick
);

  // R12
  vid_unit_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(soft_start) |-> (vid_code == $past(vid_code) ||
                            vid_code == $past(vid_code) + 1'b1 ||
                            vid_code == $past(vid_code) - 1'b1));

  // R2
  vid_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_code != $past(vid_code)) |-> $past(step_tick));

  // R4
  pwm_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_pwm |-> (!decay_mode && pg_mask));

  // R9
  ss_no_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start |-> (!force_pwm && sw_en));

  // R5
  mask_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_mask) |-> ramp_done);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |=> !ramp_done);

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> (!pg_mask && !force_pwm && !soft_start));

endmodule

bind vid_slew_ctrl vid_slew_chk #(.VID_W(VID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .decay_mode (decay_mode),
  .vid_code   (vid_code),
  .force_pwm  (force_pwm),
  .pg_mask    (pg_mask),
  .sw_en      (sw_en),
  .soft_start (soft_start),
  .ramp_done  (ramp_done),
  .step_tick  (step_tick)
);

// File: tb/test_vid_slew_ctrl.sv
module test_vid_slew_ctrl;

  localparam int VW    = 7;
  localparam int FLOOR = 4;
  localparam int CPU   = 2;
  localparam int SSU   = 20;
  localparam int SS    = CPU * SSU;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] tgt_vid = '0;
  logic          decay_mode = 1'b0, step_sel = 1'b0, below_floor = 1'b0;
  logic [VW-1:0] vid_code;
  logic          force_pwm, pg_mask, sw_en, soft_start, ramp_done;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vid_slew_ctrl #(.VID_W(VW), .FLOOR_CODE(FLOOR), .CLK_PER_US(CPU), .SS_US(SSU)) i_vid_slew_ctrl (
    .clk(clk), .rst_n(rst_n), .tgt_vid(tgt_vid), .decay_mode(decay_mode),
    .step_sel(step_sel), .below_floor(below_floor), .vid_code(vid_code),
    .force_pwm(force_pwm), .pg_mask(pg_mask), .sw_en(sw_en),
    .soft_start(soft_start), .ramp_done(ramp_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int stp();
    return step_sel ? 6 * CPU : 3 * CPU;
  endfunction

  // R2 R3 R4 R5 R6: target is already driven; checks edges j = 0..N*STEP
  task automatic run_ramp(input int from, input int to, input bit pwm_on, input string tag);
    int n = (to > from) ? to - from : from - to;
    int sg = (to > from) ? 1 : -1;
    for (int j = 0; j <= n * stp(); j++) begin
      int ev;
      bit last;
      logic [VW+2:0] act, exp;
      @(negedge clk);
      ev = from + sg * (j / stp());
      last = (j == n * stp());
      exp = {ev[VW-1:0], !last, pwm_on && !last, last};
      act = {vid_code, pg_mask, force_pwm, ramp_done};
      check(act == exp, tag, int'(act), int'(exp));
    end
  endtask

  // R8 R9: soft-start phase, vid held at v0
  task automatic run_soft(input int v0);
    for (int j = 0; j < SS; j++) begin
      logic [VW+3:0] act, exp;
      @(negedge clk);
      exp = {1'b1, 1'b1, 1'b1, 1'b0, 7'(v0)};
      act = {soft_start, sw_en, pg_mask, force_pwm, vid_code};
      check(act == exp, "R8/R9 soft-start", int'(act), int'(exp));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check({vid_code, sw_en, force_pwm, pg_mask, soft_start, ramp_done} == '0,
          "R1 reset", int'({vid_code, sw_en, force_pwm, pg_mask, soft_start, ramp_done}), 0);

    // R10: ignored while off
    tgt_vid = 7'd20; below_floor = 1'b0;
    repeat (20) @(negedge clk);
    check({vid_code, sw_en, pg_mask, soft_start} == '0, "R10 no-below",
          int'({vid_code, sw_en, pg_mask, soft_start}), 0);
    tgt_vid = 7'(FLOOR - 1); below_floor = 1'b1;
    repeat (20) @(negedge clk);
    check({vid_code, sw_en, pg_mask, soft_start} == '0, "R10 low-target",
          int'({vid_code, sw_en, pg_mask, soft_start}), 0);

    // R8 R9: restart from reset state
    tgt_vid = 7'd10;
    run_soft(0);
    run_ramp(FLOOR, 10, 1'b0, "R9 restart ramp");
    below_floor = 1'b0;
    cur = 10;

    // R4 fine down, coarse up, decay down
    tgt_vid = 7'd7; run_ramp(cur, 7, 1'b1, "R4 fine down"); cur = 7;
    step_sel = 1'b1;
    tgt_vid = 7'd12; run_ramp(cur, 12, 1'b1, "R3 coarse up"); cur = 12;
    decay_mode = 1'b1;
    tgt_vid = 7'd9; run_ramp(cur, 9, 1'b0, "R4 decay down"); cur = 9;

    // R11: retarget between ticks; timer phase kept
    step_sel = 1'b0; decay_mode = 1'b0;
    tgt_vid = 7'd15;
    for (int j = 0; j <= 18; j++) begin
      @(negedge clk);
      if (j == 14) begin
        check(vid_code == 7'd11, "R11 mid", vid_code, 11);
        tgt_vid = 7'd10;
      end
      if (j == 17) check({vid_code, pg_mask, ramp_done} == {7'd11, 1'b1, 1'b0},
                         "R11 before tick", int'({vid_code, pg_mask, ramp_done}),
                         int'({7'd11, 1'b1, 1'b0}));
      if (j == 18) check({vid_code, pg_mask, ramp_done} == {7'd10, 1'b0, 1'b1},
                         "R11 on old grid", int'({vid_code, pg_mask, ramp_done}),
                         int'({7'd10, 1'b0, 1'b1}));
    end
    cur = 10;
    @(negedge clk);
    check(ramp_done == 1'b0, "R6 pulse width", ramp_done, 0);

    // R7: shutdown
    tgt_vid = '0;
    run_ramp(cur, FLOOR, 1'b1, "R7 shutdown ramp");
    check(sw_en == 1'b0, "R7 sw off", sw_en, 0);
    repeat (10) @(negedge clk);
    check({vid_code, sw_en, pg_mask} == {7'(FLOOR), 2'b00}, "R7 held",
          int'({vid_code, sw_en, pg_mask}), int'({7'(FLOOR), 2'b00}));

    // R8 R9: restart from floor, then sweep step size x decay x targets
    below_floor = 1'b1; decay_mode = 1'b1;
    tgt_vid = 7'd8;
    run_soft(FLOOR);
    run_ramp(FLOOR, 8, 1'b0, "R9 restart decay");
    below_floor = 1'b0; cur = 8;
    for (int m = 0; m < 4; m++) begin
      step_sel = m[0]; decay_mode = m[1];
      for (int i = 0; i < 5; i++) begin
        int t = 5 + ((i * 7 + m * 3) % 14);
        if (t == cur) t = t + 1;
        tgt_vid = 7'(t);
        run_ramp(cur, t, !decay_mode, "R2 sweep");
        cur = t;
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule